// File: doc/BRIEF.md
# Playfield and Sprite Colour Mixer

This block turns one pixel's worth of raster data into a 12-bit RGB colour. Each pixel carries up to six bitplane bits, the 2-bit values of eight sprites grouped as four pairs, and a flag that says whether the pixel lies inside the display window. A 32-entry palette of 4-bit-per-component colours is loaded through a simple write port. The playfield can be read three ways: one playfield, two interleaved playfields, or hold-and-modify. In hold-and-modify, a pixel may change a single component of the previous colour.

In single-playfield mode a sixth plane selects half-brightness. Sprites are overlaid with a fixed pair ordering. A pair can be joined into one 4-bit sprite. Each playfield has its own priority code that places it between sprite pairs. Outside the window the output is the border colour held in palette entry 0.

Pixels arrive on a valid/ready stream and leave on another, one register deep. A pixel is taken when `in_valid` and `in_ready` are both high. Its colour appears on `out_rgb` with `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, the output holds and `in_ready` is low. The mode, plane-count, priority and attach pins are plain controls, sampled together with each accepted pixel.

Top module: `pf_colour_mixer`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, every palette entry is 0, and the hold-and-modify carry colour is 0.
- R2: `in_ready` is high exactly when the output register is empty or is being drained. An accepted pixel gives `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, `out_rgb` stays unchanged.
- R3: A palette write (`pal_we`, `pal_addr`, `pal_data`) affects only pixels accepted in later cycles. A pixel accepted in the same cycle as the write sees the old entry.
- R4: A pixel with `in_window` = 0 is output as palette entry 0, whatever its plane and sprite bits hold.
- R5: In single-playfield mode (`mode` = 0), the colour is the palette entry indexed by plane bits 4..0 (`in_planes[0]` is plane 1, the least significant index bit).
- R6: Plane bits at positions equal to or above `plane_cnt` (0..6) are treated as 0 in every mode.
- R7: In single-playfield mode with plane 6 set (`in_planes[5]`), the output is the entry for planes 1..5 with each 4-bit component shifted right by one.
- R8: In hold-and-modify mode (`mode` = 2), planes 6..5 are the op code and planes 4..1 are the data d. Op 00 gives palette entry d. Op 01 replaces blue (bits 3:0) with d, op 10 replaces red (bits 11:8), and op 11 replaces green (bits 7:4). The other components are kept from the carry colour.
- R9: The carry colour becomes the playfield colour of each accepted in-window pixel, not counting sprites. For an accepted border pixel it becomes palette entry 0.
- R10: In dual mode (`mode` = 1), planes 1,3,5 form playfield A (index bits 0,1,2 → entries 0..7). Planes 2,4,6 form playfield B (entries 8..15). Index 0 is transparent. `pf2_front` = 1 puts B in front of A. If both are transparent, the colour is entry 0.
- R11: Sprite k uses `in_spr[2k+1:2k]`, and pair n is sprites 2n (even) and 2n+1 (odd). A lower pair is drawn over a higher one, and an even sprite over its odd partner. Value 0 is transparent. A non-zero value v of pair n shows entry 16+4n+v.
- R12: With `attach[n]` = 1, pair n forms v = {odd bits, even bits}. A non-zero v shows entry 16+v, and v = 0 is transparent.
- R13: A non-transparent playfield with priority code p is drawn in front of the topmost visible sprite pair n when p ≤ n. In dual mode A uses `pf1_code` and B uses `pf2_code`. In the other modes any non-zero plane bit makes the playfield opaque under `pf2_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_we | input | 1 | Palette write strobe |
| pal_addr | input | 5 | Palette entry to write |
| pal_data | input | 12 | Colour to write, red in 11:8, green in 7:4, blue in 3:0 |
| mode | input | 2 | 0 single, 1 dual, 2 hold-and-modify |
| plane_cnt | input | 3 | Number of active planes, 0..6 |
| pf2_front | input | 1 | Dual mode: playfield B over A |
| pf1_code | input | 3 | Sprite priority code of playfield A |
| pf2_code | input | 3 | Sprite priority code of playfield B (or of the single playfield) |
| attach | input | 4 | Per-pair attach flags |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Mixer can take a pixel |
| in_planes | input | 6 | Bitplane bits, plane 1 at bit 0 |
| in_spr | input | 16 | Eight 2-bit sprite values |
| in_window | input | 1 | Pixel inside the display window |
| out_valid | output | 1 | Output colour valid |
| out_ready | input | 1 | Sink takes the colour |
| out_rgb | output | 12 | Mixed colour |

## Verification
A palette write and a pixel acceptance can fall in the same cycle, with the pixel reading the very entry being written. The second coincidence is a stall on the output while the next hold-and-modify pixel waits, because the carry must advance only on acceptance. Random stimulus writes the palette in about a quarter of all cycles and drops `out_ready` often, so both coincidences occur many times. The bench model applies each write only after it has computed the expected colour of any pixel accepted in that cycle, and it updates its carry only for accepted pixels. Every output handshake is then compared with the model's queue.

// File: rtl/mix_pkg.sv
package mix_pkg;
  localparam int CW      = 4;
  localparam int RGBW    = 3 * CW;
  localparam int PAL_N   = 32;
  localparam int PAL_AW  = $clog2(PAL_N);
  localparam int NPL     = 6;
  localparam int NPAIR   = 4;
  localparam int NSPR    = 2 * NPAIR;
  localparam int PAIR_W  = $clog2(NPAIR);
  localparam int SPR_BASE = 16;

  typedef logic [RGBW-1:0] rgb_t;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_DUAL   = 2'd1,
    MODE_HAM    = 2'd2
  } mix_mode_e;

  function automatic rgb_t halve_rgb(input rgb_t c);
    rgb_t r;
    for (int k = 0; k < 3; k++) r[k*CW +: CW] = c[k*CW +: CW] >> 1;
    return r;
  endfunction
endpackage

// File: rtl/mix_palette.sv
module mix_palette
  import mix_pkg::*;
#(
  parameter int N  = PAL_N,
  parameter int W  = RGBW,
  parameter int NR = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [$clog2(N)-1:0]         waddr,
  input  logic [W-1:0]                 wdata,
  input  logic [NR*$clog2(N)-1:0]      raddr,
  output logic [NR*W-1:0]              rdata,
  output logic [W-1:0]                 entry0
);
  localparam int AW = $clog2(N);

  logic [W-1:0] mem [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar r = 0; r < NR; r++) begin : g_rd
    assign rdata[r*W +: W] = mem[raddr[r*AW +: AW]];
  end

  assign entry0 = mem[0];

  // R3: a write is visible from the following cycle
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/mix_playfield.sv
module mix_playfield
  import mix_pkg::*;
(
  input  logic [NPL-1:0]    planes,
  input  logic [1:0]        mode,
  input  logic [2:0]        plane_cnt,
  input  logic              b_front,
  input  rgb_t              carry,
  input  rgb_t              pal_rd,
  output logic [PAL_AW-1:0] pal_idx,
  output rgb_t              pf_rgb,
  output logic              opq_a,
  output logic              opq_b
);
  logic [NPL-1:0] pl;
  logic [2:0]     pf_a, pf_b;
  logic [1:0]     ham_op;
  logic [CW-1:0]  ham_d;

  // R6: planes at or above the active count read as zero
  for (genvar i = 0; i < NPL; i++) begin : g_mask
    assign pl[i] = planes[i] && (i < int'(plane_cnt));
  end

  assign pf_a   = {pl[4], pl[2], pl[0]};
  assign pf_b   = {pl[5], pl[3], pl[1]};
  assign ham_op = pl[5:4];
  assign ham_d  = pl[3:0];

  always_comb begin
    pal_idx = '0;
    pf_rgb  = pal_rd;
    opq_a   = 1'b0;
    opq_b   = |pl;
    unique case (mode)
      MODE_DUAL: begin
        opq_a = |pf_a;
        opq_b = |pf_b;
        if (b_front) pal_idx = (|pf_b) ? {2'b01, pf_b} : {2'b00, pf_a};
        else         pal_idx = (|pf_a) ? {2'b00, pf_a} : ((|pf_b) ? {2'b01, pf_b} : '0);
        pf_rgb = pal_rd;
      end
      MODE_HAM: begin
        pal_idx = {1'b0, ham_d};
        unique case (ham_op)
          2'b00: pf_rgb = pal_rd;
          2'b01: pf_rgb = {carry[11:4], ham_d};
          2'b10: pf_rgb = {ham_d, carry[7:0]};
          default: pf_rgb = {carry[11:8], ham_d, carry[3:0]};
        endcase
      end
      default: begin
        pal_idx = pl[4:0];
        pf_rgb  = pl[5] ? halve_rgb(pal_rd) : pal_rd;
      end
    endcase
  end

  // R10: a transparent dual-mode pixel must index the background entry
  always_comb begin
    if (mode == MODE_DUAL && !opq_a && !opq_b)
      a_r10_bg_idx: assert (pal_idx == '0);
  end
endmodule

// File: rtl/mix_sprite.sv
module mix_sprite
  import mix_pkg::*;
(
  input  logic [2*NSPR-1:0] spr,
  input  logic [NPAIR-1:0]  attach,
  output logic              hit,
  output logic [PAIR_W-1:0] pair,
  output logic [PAL_AW-1:0] pal_idx
);
  logic [NPAIR-1:0]  p_hit;
  logic [PAL_AW-1:0] p_idx [NPAIR];

  for (genvar n = 0; n < NPAIR; n++) begin : g_pair
    logic [1:0] ev, od;
    logic [3:0] joined;
    assign ev     = spr[4*n +: 2];
    assign od     = spr[4*n+2 +: 2];
    assign joined = {od, ev};
    always_comb begin
      if (attach[n]) begin
        p_hit[n] = |joined;
        p_idx[n] = PAL_AW'(SPR_BASE) + PAL_AW'(joined);
      end else begin
        p_hit[n] = |ev || |od;
        p_idx[n] = PAL_AW'(SPR_BASE + 4*n) + PAL_AW'((|ev) ? ev : od);
      end
    end
  end

  // R11: the lowest-numbered visible pair wins
  always_comb begin
    hit     = 1'b0;
    pair    = '0;
    pal_idx = '0;
    for (int n = NPAIR - 1; n >= 0; n--) begin
      if (p_hit[n]) begin
        hit     = 1'b1;
        pair    = PAIR_W'(n);
        pal_idx = p_idx[n];
      end
    end
  end

  always_comb begin
    if (hit) a_r11_spr_range: assert (pal_idx >= PAL_AW'(SPR_BASE));
  end
endmodule

// File: rtl/pf_colour_mixer.sv
module pf_colour_mixer
  import mix_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pal_we,
  input  logic [PAL_AW-1:0]  pal_addr,
  input  logic [RGBW-1:0]    pal_data,
  input  logic [1:0]         mode,
  input  logic [2:0]         plane_cnt,
  input  logic               pf2_front,
  input  logic [2:0]         pf1_code,
  input  logic [2:0]         pf2_code,
  input  logic [NPAIR-1:0]   attach,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [NPL-1:0]     in_planes,
  input  logic [2*NSPR-1:0]  in_spr,
  input  logic               in_window,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [RGBW-1:0]    out_rgb
);
  rgb_t              carry_q, pf_rgb, spr_rgb, ent0, mix_rgb, carry_nxt;
  logic [PAL_AW-1:0] pf_idx, spr_idx;
  logic [2*RGBW-1:0] rd_flat;
  logic              opq_a, opq_b, spr_hit, pf_front, show_spr, accept;
  logic [PAIR_W-1:0] spr_pair;

  mix_palette #(.N(PAL_N), .W(RGBW), .NR(2)) u_pal (
    .clk(clk), .rst_n(rst_n), .we(pal_we), .waddr(pal_addr), .wdata(pal_data),
    .raddr({spr_idx, pf_idx}), .rdata(rd_flat), .entry0(ent0)
  );

  assign spr_rgb = rd_flat[RGBW +: RGBW];

  mix_playfield u_pf (
    .planes(in_planes), .mode(mode), .plane_cnt(plane_cnt), .b_front(pf2_front),
    .carry(carry_q), .pal_rd(rd_flat[0 +: RGBW]), .pal_idx(pf_idx),
    .pf_rgb(pf_rgb), .opq_a(opq_a), .opq_b(opq_b)
  );

  mix_sprite u_spr (
    .spr(in_spr), .attach(attach), .hit(spr_hit), .pair(spr_pair), .pal_idx(spr_idx)
  );

  // R13: playfield in front of pair n when its code is at most n
  assign pf_front  = (opq_a && pf1_code <= {1'b0, spr_pair}) ||
                     (opq_b && pf2_code <= {1'b0, spr_pair});
  assign show_spr  = in_window && spr_hit && !pf_front;
  assign mix_rgb   = !in_window ? ent0 : (show_spr ? spr_rgb : pf_rgb);
  assign carry_nxt = in_window ? pf_rgb : ent0;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
      carry_q   <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_rgb   <= mix_rgb;
        carry_q   <= carry_nxt;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rgb));

  a_r2_fill: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  a_r4_border: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_window |=> out_rgb == $past(ent0));

  a_r9_keep_rg: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_window && !show_spr && mode == MODE_HAM && plane_cnt >= 3'd6 &&
    in_planes[5:4] == 2'b01 |=> out_rgb[11:4] == $past(carry_q[11:4]));
endmodule

// File: tb/pf_colour_mixer_test.sv
module pf_colour_mixer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pal_we = 1'b0;
  logic [4:0]  pal_addr = '0;
  logic [11:0] pal_data = '0;
  logic [1:0]  mode = '0;
  logic [2:0]  plane_cnt = '0;
  logic        pf2_front = 1'b0;
  logic [2:0]  pf1_code = '0, pf2_code = '0;
  logic [3:0]  attach = '0;
  logic        in_valid = 1'b0, in_ready;
  logic [5:0]  in_planes = '0;
  logic [15:0] in_spr = '0;
  logic        in_window = 1'b0;
  logic        out_valid, out_ready = 1'b0;
  logic [11:0] out_rgb;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [11:0] m_pal [32];
  logic [11:0] m_carry;
  logic [11:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  pf_colour_mixer uut (.*);

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] halve(input logic [11:0] c);
    return {1'b0, c[11:9], 1'b0, c[7:5], 1'b0, c[3:1]};
  endfunction

  task automatic model(output logic [11:0] col, output string tag);
    logic [5:0]  pl;
    logic [2:0]  a, b;
    logic [11:0] pfc;
    logic        oa, ob, hit, front;
    int          pair, sidx;
    pl = in_planes;
    for (int i = 0; i < 6; i++) if (i >= int'(plane_cnt)) pl[i] = 1'b0;
    a = {pl[4], pl[2], pl[0]};
    b = {pl[5], pl[3], pl[1]};
    tag = (plane_cnt < 3'd6 && in_planes != pl) ? "R6" : "R5";
    oa = 1'b0; ob = |pl;
    if (mode == 2'd1) begin
      oa = |a; ob = |b; tag = "R10";
      if (pf2_front) pfc = (|b) ? m_pal[{2'b01, b}] : m_pal[{2'b00, a}];
      else pfc = (|a) ? m_pal[{2'b00, a}] : ((|b) ? m_pal[{2'b01, b}] : m_pal[0]);
    end else if (mode == 2'd2) begin
      tag = (pl[5:4] == 2'b00) ? "R8" : "R9";
      case (pl[5:4])
        2'b00: pfc = m_pal[{1'b0, pl[3:0]}];
        2'b01: pfc = {m_carry[11:4], pl[3:0]};
        2'b10: pfc = {pl[3:0], m_carry[7:0]};
        default: pfc = {m_carry[11:8], pl[3:0], m_carry[3:0]};
      endcase
    end else begin
      pfc = pl[5] ? halve(m_pal[pl[4:0]]) : m_pal[pl[4:0]];
      if (pl[5]) tag = "R7";
    end
    hit = 1'b0; pair = 0; sidx = 0;
    for (int n = 3; n >= 0; n--) begin
      logic [1:0] e, o;
      e = in_spr[4*n +: 2]; o = in_spr[4*n+2 +: 2];
      if (attach[n]) begin
        if ({o, e} != 4'd0) begin hit = 1'b1; pair = n; sidx = 16 + int'({o, e}); end
      end else if (e != 0) begin hit = 1'b1; pair = n; sidx = 16 + 4*n + int'(e); end
      else if (o != 0) begin hit = 1'b1; pair = n; sidx = 16 + 4*n + int'(o); end
    end
    front = (oa && int'(pf1_code) <= pair) || (ob && int'(pf2_code) <= pair);
    if (!in_window) begin
      col = m_pal[0]; tag = "R4"; m_carry = m_pal[0];
    end else begin
      if (hit && !front) begin
        col = m_pal[sidx];
        tag = attach[pair] ? "R12" : "R11";
      end else begin
        col = pfc;
        if (hit) tag = "R13";
      end
      m_carry = pfc;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] e, prev_rgb;
    logic        prev_stall;
    string       t;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) m_pal[i] = '0;
    m_carry = '0;
    repeat (3) @(negedge clk);
    checks++; if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++; $display("FAIL R1: actual=%b%b expected=01", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", out_rgb, 12'h000);
    // R1: first HAM pixel modifies a zero carry; R3: same-cycle write sees old
    mode = 2'd2; plane_cnt = 3'd6; in_window = 1'b1; in_valid = 1'b1; out_ready = 1'b1;
    in_planes = 6'b01_1010; pal_we = 1'b1; pal_addr = 5'd0; pal_data = 12'hABC;
    @(negedge clk);
    chk("R1", out_rgb, 12'h00A);
    m_carry = 12'h00A; m_pal[0] = 12'hABC;
    in_planes = 6'b00_0000; pal_we = 1'b0;
    @(negedge clk);
    chk("R3", out_rgb, 12'hABC);
    m_carry = 12'hABC;
    in_valid = 1'b0;
    @(negedge clk);
    prev_stall = 1'b0; prev_rgb = '0;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      if (prev_stall) chk("R2", out_rgb, prev_rgb);
      pal_we    = ($urandom % 4) == 0;
      pal_addr  = 5'($urandom);
      pal_data  = 12'($urandom);
      mode      = 2'($urandom % 3);
      plane_cnt = 3'($urandom % 7);
      if (($urandom % 3) != 0) plane_cnt = 3'd6;
      pf2_front = 1'($urandom);
      pf1_code  = 3'($urandom % 5);
      pf2_code  = 3'($urandom % 5);
      attach    = 4'($urandom);
      in_valid  = ($urandom % 4) != 0;
      in_planes = 6'($urandom);
      in_spr    = 16'($urandom) & 16'($urandom) & 16'($urandom);
      in_window = ($urandom % 8) != 0;
      out_ready = ($urandom % 3) != 0;
      #1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk("R2", out_rgb, 12'hxxx);
        else begin e = exp_q.pop_front(); t = tag_q.pop_front(); chk(t, out_rgb, e); end
      end
      prev_stall = out_valid && !out_ready;
      prev_rgb   = out_rgb;
      if (in_valid && in_ready) begin
        model(e, t);
        exp_q.push_back(e); tag_q.push_back(t);
      end
      if (pal_we) m_pal[pal_addr] = pal_data;
    end
    @(negedge clk);
    in_valid = 1'b0; pal_we = 1'b0; out_ready = 1'b1;
    repeat (3) begin
      #1;
      if (out_valid && exp_q.size() > 0) begin
        e = exp_q.pop_front(); t = tag_q.pop_front(); chk(t, out_rgb, e);
      end
      @(negedge clk);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule